// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two component predictors on every lookup. The first is a per-address table of 2-bit saturating counters. It suits branches that nearly always go the same way. The second is a global-history predictor. A shift register holds recent branch outcomes; that register is XORed with low address bits, and the result selects a counter in a second counter table. A third table, also selected by address, learns for each branch which component has been right more often and routes that component's answer to the final output.

Lookup is combinational. The fetch stage drives the branch address and receives the final direction. It also receives both component answers and the global-table index it used, and it carries these alongside the branch. When the branch resolves, the pipeline presents the address, the real outcome and that carried snapshot on the update port. All three tables and the history register then change at the next clock edge. The update uses the stored index rather than recomputing it, so a history that has moved on since the lookup does not misdirect training.

Top module: `tourney_dir_pred`

## Requirements
- R1: After reset every direction counter holds weakly not-taken (2'b01), every selector counter holds weakly prefer-per-address (2'b01), and the history register is zero, so every lookup returns not-taken from both components with the per-address component selected.
- R2: The per-address counter is chosen by address bits [PC_LSB +: BIM_IDX_W]. A counter predicts taken when its upper bit is 1. On an update it steps up by one on a taken outcome and down by one on a not-taken outcome.
- R3: The global-table lookup index is the history register, zero-extended to GSH_IDX_W, XORed with address bits [PC_LSB +: GSH_IDX_W], and it appears on `pred_gsh_idx`.
- R4: Each valid update shifts the real outcome into bit 0 of the history register (1 = taken), and older bits move one place up.
- R5: A valid update trains the global counter at the index given on `upd_gsh_idx`, not at an index recomputed from the current history.
- R6: The selector counter at address bits [PC_LSB +: CHO_IDX_W] steps up when only the global snapshot matched the outcome. It steps down when only the per-address snapshot matched. It is left unchanged when both matched or neither did.
- R7: The final prediction equals the global component's answer when the selected selector counter's upper bit is 1, and the per-address answer otherwise. `pred_use_gsh` shows which one was used.
- R8: Both direction counters are trained on every valid update whichever component the selector favoured.
- R9: All counters saturate: a counter at 2'b11 stays there on a step up, and a counter at 2'b00 stays there on a step down.
- R10: With `upd_valid` low, no table and no history bit changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Final direction (1 = taken) |
| pred_bim_taken | output | 1 | Per-address component answer |
| pred_gsh_taken | output | 1 | Global-history component answer |
| pred_gsh_idx | output | GSH_IDX_W | Global-table index used for this lookup |
| pred_use_gsh | output | 1 | 1 when the global component supplied the final answer |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome (1 = taken) |
| upd_bim_taken | input | 1 | Per-address answer captured at lookup |
| upd_gsh_taken | input | 1 | Global answer captured at lookup |
| upd_gsh_idx | input | GSH_IDX_W | Global-table index captured at lookup |

## Verification
Faults in this block hide in stored state, so they show at the ports only when a later lookup reads the damaged entry. A lookup in the cycle after an update already reflects it. A wrong step or a missing saturation at one counter shows as a wrong component answer on the next lookup of that address or index. A history that shifts the wrong way shows at once on `pred_gsh_idx` for any address. A selector that trains on the wrong condition shows only after enough disagreeing outcomes, as `pred_use_gsh` failing to flip. The bench keeps a reference model of all tables and compares every output on every lookup. Long directed sequences on one address drive each counter across both saturation ends and make the selector change sides.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_STRONG_LO = 2'b00;
   localparam ctr2_t CTR_WEAK_LO   = 2'b01;
   localparam ctr2_t CTR_STRONG_HI = 2'b11;

   // Saturating step: up wins only when asked alone, same for down.
   function automatic ctr2_t ctr_step(input ctr2_t cur, input logic up, input logic dn);
      ctr2_t nxt;
      nxt = cur;
      if (up && !dn && cur != CTR_STRONG_HI)
         nxt = cur + 2'd1;
      else if (dn && !up && cur != CTR_STRONG_LO)
         nxt = cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/tdp_ctr_table.sv
module tdp_ctr_table
   import tdp_pkg::*;
#(
   parameter int    IDX_W = 6,
   parameter ctr2_t INIT  = CTR_WEAK_LO
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr2_t            rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_inc,
   input  logic             wr_dec
);

   localparam int DEPTH = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("tdp_ctr_table: IDX_W out of range");
      end
   endgenerate

   ctr2_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
      end else if (wr_en) begin
         mem[wr_idx] <= ctr_step(mem[wr_idx], wr_inc, wr_dec);
      end
   end

   assign rd_ctr = mem[rd_idx];

   AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_inc && !wr_dec && mem[wr_idx] == CTR_STRONG_HI)
      |=> mem[$past(wr_idx)] == CTR_STRONG_HI); // R9
   AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_dec && !wr_inc && mem[wr_idx] == CTR_STRONG_LO)
      |=> mem[$past(wr_idx)] == CTR_STRONG_LO); // R9
   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_inc && !wr_dec && mem[wr_idx] != CTR_STRONG_HI)
      |=> mem[$past(wr_idx)] > $past(mem[wr_idx])); // R2
   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_dec && !wr_inc && mem[wr_idx] != CTR_STRONG_LO)
      |=> mem[$past(wr_idx)] < $past(mem[wr_idx])); // R2
   AST_HOLD_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_inc && !wr_dec)
      |=> mem[$past(wr_idx)] == $past(mem[wr_idx])); // R6
   AST_NO_BOTH_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !(wr_inc && wr_dec)); // R6

endmodule

// File: rtl/tdp_ghist.sv
module tdp_ghist #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         shift_bit,
   output logic [W-1:0] hist
);

   generate
      if (W < 1) begin : g_bad_w
         $error("tdp_ghist: W must be at least 1");
      end
      if (W == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n)        hist <= '0;
            else if (shift_en) hist <= shift_bit;
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (!rst_n)        hist <= '0;
            else if (shift_en) hist <= {hist[W-2:0], shift_bit};
         end
         AST_HIST_AGE: assert property (@(posedge clk) disable iff (!rst_n)
            shift_en |=> hist[W-1:1] == $past(hist[W-2:0])); // R4
      end
   endgenerate

   AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> hist[0] == $past(shift_bit)); // R4
   AST_HIST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist)); // R10

endmodule

// File: rtl/tourney_dir_pred.sv
module tourney_dir_pred
   import tdp_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int PC_LSB    = 2,
   parameter int BIM_IDX_W = 6,
   parameter int GSH_IDX_W = 6,
   parameter int GHR_W     = 6,
   parameter int CHO_IDX_W = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PC_W-1:0]      pred_pc,
   output logic                 pred_taken,
   output logic                 pred_bim_taken,
   output logic                 pred_gsh_taken,
   output logic [GSH_IDX_W-1:0] pred_gsh_idx,
   output logic                 pred_use_gsh,
   input  logic                 upd_valid,
   input  logic [PC_W-1:0]      upd_pc,
   input  logic                 upd_taken,
   input  logic                 upd_bim_taken,
   input  logic                 upd_gsh_taken,
   input  logic [GSH_IDX_W-1:0] upd_gsh_idx
);

   localparam int MAX_IDX_W = (BIM_IDX_W > GSH_IDX_W)
                              ? ((BIM_IDX_W > CHO_IDX_W) ? BIM_IDX_W : CHO_IDX_W)
                              : ((GSH_IDX_W > CHO_IDX_W) ? GSH_IDX_W : CHO_IDX_W);
   localparam int PAD_W = GSH_IDX_W - GHR_W;

   generate
      if (PC_LSB + MAX_IDX_W > PC_W) begin : g_bad_pc
         $error("tourney_dir_pred: index bits exceed PC width");
      end
      if (GHR_W > GSH_IDX_W) begin : g_bad_ghr
         $error("tourney_dir_pred: history longer than global index");
      end
   endgenerate

   // Lookup indices
   logic [BIM_IDX_W-1:0] bim_rd_idx, bim_wr_idx;
   logic [CHO_IDX_W-1:0] cho_rd_idx, cho_wr_idx;
   logic [GSH_IDX_W-1:0] hist_ext;
   logic [GHR_W-1:0]     ghr;

   assign bim_rd_idx = pred_pc[PC_LSB +: BIM_IDX_W];
   assign bim_wr_idx = upd_pc[PC_LSB +: BIM_IDX_W];
   assign cho_rd_idx = pred_pc[PC_LSB +: CHO_IDX_W];
   assign cho_wr_idx = upd_pc[PC_LSB +: CHO_IDX_W];

   generate
      if (PAD_W == 0) begin : g_hist_full
         assign hist_ext = ghr;
      end else begin : g_hist_pad
         assign hist_ext = {{PAD_W{1'b0}}, ghr};
      end
   endgenerate

   assign pred_gsh_idx = hist_ext ^ pred_pc[PC_LSB +: GSH_IDX_W];

   // Chooser training direction
   logic bim_hit, gsh_hit, cho_inc, cho_dec;
   assign bim_hit = (upd_bim_taken == upd_taken);
   assign gsh_hit = (upd_gsh_taken == upd_taken);
   assign cho_inc = gsh_hit && !bim_hit;
   assign cho_dec = bim_hit && !gsh_hit;

   ctr2_t bim_ctr, gsh_ctr, cho_ctr;

   tdp_ctr_table #(.IDX_W(BIM_IDX_W), .INIT(CTR_WEAK_LO)) u_bim (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (bim_rd_idx),
      .rd_ctr (bim_ctr),
      .wr_en  (upd_valid),
      .wr_idx (bim_wr_idx),
      .wr_inc (upd_taken),
      .wr_dec (!upd_taken)
   );

   tdp_ctr_table #(.IDX_W(GSH_IDX_W), .INIT(CTR_WEAK_LO)) u_gsh (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (pred_gsh_idx),
      .rd_ctr (gsh_ctr),
      .wr_en  (upd_valid),
      .wr_idx (upd_gsh_idx),
      .wr_inc (upd_taken),
      .wr_dec (!upd_taken)
   );

   tdp_ctr_table #(.IDX_W(CHO_IDX_W), .INIT(CTR_WEAK_LO)) u_cho (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (cho_rd_idx),
      .rd_ctr (cho_ctr),
      .wr_en  (upd_valid),
      .wr_idx (cho_wr_idx),
      .wr_inc (cho_inc),
      .wr_dec (cho_dec)
   );

   tdp_ghist #(.W(GHR_W)) u_ghist (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (upd_valid),
      .shift_bit (upd_taken),
      .hist      (ghr)
   );

   assign pred_bim_taken = bim_ctr[1];
   assign pred_gsh_taken = gsh_ctr[1];
   assign pred_use_gsh   = cho_ctr[1];
   assign pred_taken     = pred_use_gsh ? pred_gsh_taken : pred_bim_taken;

   logic unused_pc_bits;
   assign unused_pc_bits = ^{pred_pc, upd_pc};

   AST_UPD_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> !$isunknown({upd_taken, upd_bim_taken, upd_gsh_taken, upd_gsh_idx})); // R8

endmodule

// File: tb/tourney_dir_pred_bench.sv
module tourney_dir_pred_bench;

   localparam int IW = 6;
   localparam int DEPTH = 1 << IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   pred_pc = '0;
   logic          pred_taken, pred_bim_taken, pred_gsh_taken, pred_use_gsh;
   logic [IW-1:0] pred_gsh_idx;
   logic          upd_valid = 1'b0;
   logic [31:0]   upd_pc = '0;
   logic          upd_taken = 1'b0, upd_bim_taken = 1'b0, upd_gsh_taken = 1'b0;
   logic [IW-1:0] upd_gsh_idx = '0;

   always #2.5 clk = ~clk;

   tourney_dir_pred u_tourney_dir_pred (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
      .pred_taken(pred_taken), .pred_bim_taken(pred_bim_taken),
      .pred_gsh_taken(pred_gsh_taken), .pred_gsh_idx(pred_gsh_idx),
      .pred_use_gsh(pred_use_gsh), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_taken(upd_taken), .upd_bim_taken(upd_bim_taken),
      .upd_gsh_taken(upd_gsh_taken), .upd_gsh_idx(upd_gsh_idx)
   );

   // Reference model
   logic [1:0]    m_bim [DEPTH];
   logic [1:0]    m_gsh [DEPTH];
   logic [1:0]    m_cho [DEPTH];
   logic [IW-1:0] m_ghr;

   typedef struct {
      logic          t, b, g, u;
      logic [IW-1:0] idx;
      string         tag;
   } exp_t;
   exp_t sbq [$];

   int total = 0;
   int bad = 0;
   bit done = 0;

   function automatic logic [1:0] sat(input logic [1:0] c, input logic up, input logic dn);
      if (up && !dn && c != 2'b11) return c + 2'd1;
      if (dn && !up && c != 2'b00) return c - 2'd1;
      return c;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // Monitor: pops expectations and compares once outputs settle
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk({e.tag, " R7"}, "pred_taken", int'(pred_taken), int'(e.t));
            chk({e.tag, " R2"}, "pred_bim_taken", int'(pred_bim_taken), int'(e.b));
            chk(e.tag, "pred_gsh_taken", int'(pred_gsh_taken), int'(e.g));
            chk({e.tag, " R6"}, "pred_use_gsh", int'(pred_use_gsh), int'(e.u));
            chk({e.tag, " R3"}, "pred_gsh_idx", int'(pred_gsh_idx), int'(e.idx));
         end
      end
   end

   // Driver: one lookup plus one (possibly invalid) update per cycle
   task automatic step(input logic [31:0] ppc, input logic uv, input logic [31:0] upc,
                       input logic ut, input logic ub, input logic ug,
                       input logic [IW-1:0] uidx, input string tag);
      exp_t e;
      logic [IW-1:0] bi, gi, ci;
      @(negedge clk);
      bi = ppc[2 +: IW];
      gi = m_ghr ^ ppc[2 +: IW];
      e.b = m_bim[bi][1];
      e.g = m_gsh[gi][1];
      e.u = m_cho[bi][1];
      e.t = e.u ? e.g : e.b;
      e.idx = gi;
      e.tag = tag;
      sbq.push_back(e);
      pred_pc = ppc;
      upd_valid = uv; upd_pc = upc; upd_taken = ut;
      upd_bim_taken = ub; upd_gsh_taken = ug; upd_gsh_idx = uidx;
      if (uv) begin
         ci = upc[2 +: IW];
         m_bim[ci] = sat(m_bim[ci], ut, !ut);
         m_gsh[uidx] = sat(m_gsh[uidx], ut, !ut);
         m_cho[ci] = sat(m_cho[ci], (ug == ut) && (ub != ut), (ub == ut) && (ug != ut));
         m_ghr = {m_ghr[IW-2:0], ut};
      end
   endtask

   // Lookup a branch and resolve it in the same cycle with its own snapshot
   task automatic branch(input logic [31:0] pc, input logic t, input string tag);
      logic [IW-1:0] gi;
      gi = m_ghr ^ pc[2 +: IW];
      step(pc, 1'b1, pc, t, m_bim[pc[2 +: IW]][1], m_gsh[gi][1], gi, tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      for (int i = 0; i < DEPTH; i++) begin
         m_bim[i] = 2'b01; m_gsh[i] = 2'b01; m_cho[i] = 2'b01;
      end
      m_ghr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state seen through lookups, no updates
      for (int i = 0; i < 8; i++)
         step(32'h100 + i * 52, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R1");

      // R10: invalid updates with busy payloads change nothing
      for (int i = 0; i < 6; i++)
         step(32'h40, 1'b0, 32'h40, 1'b1, 1'b0, 1'b1, 6'h10, "R10");
      step(32'h40, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R10");

      // R2 and R9: drive one address up to saturation and back down to saturation
      for (int i = 0; i < 6; i++) branch(32'h0000_0080, 1'b1, "R9");
      for (int i = 0; i < 7; i++) branch(32'h0000_0080, 1'b0, "R9");
      step(32'h0000_0080, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R2");

      // R4 and R3: history pattern visible on the global index
      branch(32'h0000_0200, 1'b1, "R4");
      branch(32'h0000_0200, 1'b0, "R4");
      branch(32'h0000_0200, 1'b1, "R4");
      branch(32'h0000_0200, 1'b1, "R4");
      step(32'h0000_0200, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R3");
      step(32'h0000_02FC, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R3");

      // R5: train a global entry through an arbitrary stored index
      step(32'h300, 1'b1, 32'h300, 1'b1, 1'b0, 1'b0, 6'h2A, "R5");
      step(32'h300, 1'b1, 32'h300, 1'b1, 1'b0, 1'b0, 6'h2A, "R5");
      step({24'b0, m_ghr ^ 6'h2A, 2'b00}, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R5");

      // R6, R7, R8: alternating branch; global side learns, selector flips
      for (int i = 0; i < 40; i++) branch(32'h0000_0400, i[0], "R6");
      for (int i = 0; i < 20; i++) branch(32'h0000_0400, i[0], "R7");

      // R6: both snapshots right or both wrong leaves the selector alone
      step(32'h500, 1'b1, 32'h500, 1'b1, 1'b1, 1'b1, 6'h01, "R6");
      step(32'h500, 1'b1, 32'h500, 1'b1, 1'b0, 1'b0, 6'h02, "R6");
      step(32'h500, 1'b1, 32'h500, 1'b0, 1'b1, 1'b1, 6'h03, "R6");
      step(32'h500, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R6");

      // R8: mixed traffic, both tables trained whatever the selector says
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         branch({24'b0, lfsr[5:0], 2'b00}, lfsr[7] | lfsr[3], "R8");
      end
      step(32'h0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R8");

      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule